// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache placed between a CPU request port and a main-memory port that moves whole 128-bit lines. The CPU presents one word-sized access at a time with a valid strobe, a type bit, a 32-bit word address and 32-bit write data. The cache answers with the read word and a one-cycle completion pulse. Memory traffic only happens on a miss, and every memory transfer waits for a ready handshake.

There are 64 lines. Each line holds four 32-bit words together with a tag, a valid flag and a dirty flag. Writes stay in the cache and mark the line dirty. If a miss lands on a dirty line, the old line is first written back to memory in full, and only then is the new line fetched. Both read misses and write misses allocate a line. The requested word access is then repeated against the freshly loaded line, so it completes as a hit.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset, every line is invalid and clean, and `busy`, `rsp_done`, `mem_rd` and `mem_wr` are low. A dirty line that existed before a reset is dropped and never written back.
- R2: The word address splits into a word offset `req_addr[1:0]`, a line index `req_addr[7:2]` and a tag `req_addr[31:8]`. Word offset w occupies bits [32w+31:32w] of a 128-bit line on both memory buses.
- R3: A hit requires the line to be valid and its stored tag to equal the request tag. A read hit returns the addressed word with `rsp_done` high on the second rising edge after acceptance, and it causes no memory transfer.
- R4: A write hit (`req_write` = 1; 0 means read) replaces only the addressed word, marks the line dirty, completes in the same two edges and causes no memory transfer.
- R5: A miss on a valid dirty line raises `mem_wr` with the whole victim line on `mem_wdata` and `mem_addr` = {victim tag, index, 2'b00}. These are held stable until `mem_ready`, and a refill follows directly.
- R6: A miss on an invalid or clean line performs no write-back. It raises `mem_rd` with `mem_addr` = {request tag, index, 2'b00}, held until `mem_ready`, and loads `mem_rdata` into the line.
- R7: After a refill, a read returns the addressed word of the new line and leaves the line clean. A write merges its word into the new line and leaves the line dirty. `rsp_done` follows two edges after the accepted refill.
- R8: `busy` is high from the edge that accepts a request until the edge that raises `rsp_done`. While it is high, `req_valid` is ignored.
- R9: `rsp_done` is a single-cycle pulse. `rsp_rdata` changes only on the edge that raises `rsp_done` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 0 = read, 1 = write |
| req_addr | input | 32 | Word address |
| req_wdata | input | 32 | Write word |
| rsp_rdata | output | 32 | Read word, valid when `rsp_done` pulses |
| rsp_done | output | 1 | Completion pulse |
| busy | output | 1 | A request is in progress |
| mem_addr | output | 32 | Line address (offset bits zero) |
| mem_rd | output | 1 | Refill request |
| mem_wr | output | 1 | Write-back request |
| mem_wdata | output | 128 | Victim line being written back |
| mem_rdata | input | 128 | Refill line from memory |
| mem_ready | input | 1 | Memory completes the current transfer |

## Verification
The bench uses a flat word-memory model as its reference. Every read must return the last value written to that address anywhere in the system, so a lost write-back, a write-back of the wrong line or a misplaced word shows up later as stale data. Conflict sequences on a single index alternate between clean and dirty victims at low and all-ones tags. A design that skips the write-back, uses the request tag for the victim address, or leaves a read-refilled line dirty produces the wrong number of memory transfers or the wrong addresses. Directed cases hold `req_valid` high with a conflicting write while the cache is busy, which catches a controller that accepts a second request. A dirty line discarded by reset must produce no write-back, which catches a reset that leaves valid or dirty flags behind.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_WRITEBACK,
    ST_REFILL,
    ST_FINISH
  } dmc_state_t;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  off
);
  function automatic logic [TAG_W-1:0] get_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] get_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [OFF_W-1:0] get_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  assign tag = get_tag(addr);
  assign idx = get_idx(addr);
  assign off = get_off(addr);
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int LINES  = 64,
  parameter int TAG_W  = 24,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              word_we,
  input  logic [OFF_W-1:0]  word_off,
  input  logic [WORD_W-1:0] word_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [LINE_W-1:0] rd_line
);
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [LINE_W-1:0] data_q  [LINES];
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;

  function automatic logic [LINE_W-1:0] merge_word(
    input logic [LINE_W-1:0] line,
    input logic [OFF_W-1:0]  off,
    input logic [WORD_W-1:0] w
  );
    logic [LINE_W-1:0] r;
    r = line;
    for (int k = 0; k < WORDS; k++) begin
      if (off == OFF_W'(k)) r[k*WORD_W +: WORD_W] = w;
    end
    return r;
  endfunction

  assign rd_tag   = tag_q[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_line  = data_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (word_we) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[idx]  <= fill_tag;
      data_q[idx] <= fill_line;
    end else if (word_we) begin
      data_q[idx] <= merge_word(data_q[idx], word_off, word_data);
    end
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       hit,
  input  logic       victim_dirty,
  input  logic       mem_ready,
  output dmc_state_t state,
  output logic       accept,
  output logic       access_now,
  output logic       fill_now
);
  dmc_state_t nxt;

  assign accept     = (state == ST_IDLE) && req_valid;
  assign access_now = ((state == ST_COMPARE) && hit) || (state == ST_FINISH);
  assign fill_now   = (state == ST_REFILL) && mem_ready;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      if (req_valid) nxt = ST_COMPARE;
      ST_COMPARE: begin
        if (hit)               nxt = ST_IDLE;
        else if (victim_dirty) nxt = ST_WRITEBACK;
        else                   nxt = ST_REFILL;
      end
      ST_WRITEBACK: if (mem_ready) nxt = ST_REFILL;
      ST_REFILL:    if (mem_ready) nxt = ST_FINISH;
      ST_FINISH:    nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 64,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  dmc_state_t        state;
  logic              accept, access_now, fill_now;
  logic [ADDR_W-1:0] q_addr;
  logic              q_write;
  logic [WORD_W-1:0] q_wdata;
  logic [TAG_W-1:0]  q_tag, rd_tag;
  logic [IDX_W-1:0]  q_idx;
  logic [OFF_W-1:0]  q_off;
  logic              rd_valid, rd_dirty;
  logic [LINE_W-1:0] rd_line;
  logic              hit, victim_dirty;
  // named events for the checker
  logic              cmp_hit;

  function automatic logic [WORD_W-1:0] pick_word(
    input logic [LINE_W-1:0] line,
    input logic [OFF_W-1:0]  off
  );
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (off == OFF_W'(k)) w = line[k*WORD_W +: WORD_W];
    end
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_addr  <= '0;
      q_write <= 1'b0;
      q_wdata <= '0;
    end else if (accept) begin
      q_addr  <= req_addr;
      q_write <= req_write;
      q_wdata <= req_wdata;
    end
  end

  dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .addr (q_addr),
    .tag  (q_tag),
    .idx  (q_idx),
    .off  (q_off)
  );

  dmc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (q_idx),
    .fill_en   (fill_now),
    .fill_tag  (q_tag),
    .fill_line (mem_rdata),
    .word_we   (access_now && q_write),
    .word_off  (q_off),
    .word_data (q_wdata),
    .rd_tag    (rd_tag),
    .rd_valid  (rd_valid),
    .rd_dirty  (rd_dirty),
    .rd_line   (rd_line)
  );

  assign hit          = rd_valid && (rd_tag == q_tag);
  assign victim_dirty = rd_valid && rd_dirty;
  assign cmp_hit      = (state == ST_COMPARE) && hit;

  dmc_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .hit          (hit),
    .victim_dirty (victim_dirty),
    .mem_ready    (mem_ready),
    .state        (state),
    .accept       (accept),
    .access_now   (access_now),
    .fill_now     (fill_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= access_now;
      if (access_now && !q_write) rsp_rdata <= pick_word(rd_line, q_off);
    end
  end

  assign busy      = (state != ST_IDLE);
  assign mem_wr    = (state == ST_WRITEBACK);
  assign mem_rd    = (state == ST_REFILL);
  assign mem_wdata = rd_line;
  assign mem_addr  = (state == ST_WRITEBACK) ? {rd_tag, q_idx, {OFF_W{1'b0}}}
                                             : {q_tag,  q_idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/dmc_chk.sv
module dmc_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int LINE_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              rsp_done,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LINE_W-1:0] mem_wdata,
  input logic              cmp_hit,
  input logic              fill_now
);
  p_one_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_wb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  p_wb_then_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_ready) |=> mem_rd);

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  p_hit_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> (rsp_done && !mem_rd && !mem_wr));

  p_fill_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_now |=> ##1 rsp_done);

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> $stable(rsp_rdata));
endmodule

bind dm_wb_cache dmc_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .rsp_done  (rsp_done),
  .rsp_rdata (rsp_rdata),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .cmp_hit   (cmp_hit),
  .fill_now  (fill_now)
);

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic [31:0]  rsp_rdata;
  logic         rsp_done, busy, mem_rd, mem_wr;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  always #2 clk = ~clk;

  dm_wb_cache u_dm_wb_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .busy(busy), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  int total = 0;
  int bad   = 0;

  // reference: flat word memory (aliased on 10 address bits) and line memory model
  logic [31:0]  gold [1024];
  logic [127:0] bmem [256];
  int           mem_lat = 0;
  int           wb_n = 0, rf_n = 0;
  logic [31:0]  wb_addr_last = '0, rf_addr_last = '0;
  logic [127:0] wb_data_last = '0;

  function automatic logic [31:0] init_word(input int a);
    return 32'hC0DE_0000 ^ (a * 32'h0001_0003);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  kind;   // 0 hit, 1 clean miss, 2 dirty miss
    logic [31:0] wbaddr;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b0, 32'h0000_0014, 32'h0,           2'd1, 32'h0},
    '{1'b0, 32'h0000_0016, 32'h0,           2'd0, 32'h0},
    '{1'b1, 32'h0000_0017, 32'hDEAD_BEEF,   2'd0, 32'h0},
    '{1'b0, 32'h0000_0017, 32'h0,           2'd0, 32'h0},
    '{1'b0, 32'h0000_0114, 32'h0,           2'd2, 32'h0000_0014},
    '{1'b0, 32'h0000_0017, 32'h0,           2'd1, 32'h0},
    '{1'b1, 32'h0000_0220, 32'h1234_5678,   2'd1, 32'h0},
    '{1'b0, 32'h0000_0221, 32'h0,           2'd0, 32'h0},
    '{1'b1, 32'h0000_0320, 32'hCAFE_F00D,   2'd2, 32'h0000_0220},
    '{1'b0, 32'h0000_0220, 32'h0,           2'd2, 32'h0000_0320},
    '{1'b0, 32'h0000_0320, 32'h0,           2'd1, 32'h0},
    '{1'b0, 32'h0000_00FF, 32'h0,           2'd1, 32'h0},
    '{1'b0, 32'hFFFF_FFFC, 32'h0,           2'd1, 32'h0},
    '{1'b1, 32'hFFFF_FFFE, 32'h0F0F_0F0F,   2'd0, 32'h0},
    '{1'b0, 32'h0000_00FC, 32'h0,           2'd2, 32'hFFFF_FFFC},
    '{1'b0, 32'hFFFF_FFFE, 32'h0,           2'd1, 32'h0}
  };

  // memory responder
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    forever begin
      @(negedge clk);
      if ((mem_wr || mem_rd) && !mem_ready) begin
        if (wait_cnt >= mem_lat) begin
          mem_ready = 1'b1;
          wait_cnt  = 0;
          if (mem_wr) begin
            bmem[mem_addr[9:2]] = mem_wdata;
            wb_n++;
            wb_addr_last = mem_addr;
            wb_data_last = mem_wdata;
          end else begin
            mem_rdata = bmem[mem_addr[9:2]];
            rf_n++;
            rf_addr_last = mem_addr;
          end
        end else begin
          wait_cnt++;
        end
      end else begin
        mem_ready = 1'b0;
      end
    end
  end

  // one request; returns the number of negedges to completion
  task automatic do_req(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        output int lat, output logic [31:0] rd);
    logic [31:0] held;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk(rsp_done, "R8 completion seen", 128'(rsp_done), 128'd1);
    rd = rsp_rdata;
    held = rsp_rdata;
    chk(!busy, "R8 busy low at done", 128'(busy), 128'd0);
    @(negedge clk);
    chk(!rsp_done, "R9 done single pulse", 128'(rsp_done), 128'd0);
    chk(rsp_rdata == held, "R9 rdata held", 128'(rsp_rdata), 128'(held));
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] rd;
    int wb0, rf0;
    for (int a = 0; a < 1024; a++) gold[a] = init_word(a);
    for (int b = 0; b < 256; b++)
      for (int w = 0; w < 4; w++) bmem[b][32*w +: 32] = init_word(b*4 + w);

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !rsp_done && !mem_rd && !mem_wr, "R1 outputs in reset",
        128'({busy, rsp_done, mem_rd, mem_wr}), 128'd0);
    rst_n = 1'b1;

    // vector walk
    for (int i = 0; i < 16; i++) begin
      vec_t v;
      v = VECS[i];
      mem_lat = i % 3;
      wb0 = wb_n; rf0 = rf_n;
      do_req(v.wr, v.addr, v.data, lat, rd);
      if (v.kind == 2'd0) begin
        chk(lat == 2, "R3/R4 hit latency", 128'(lat), 128'd2);
      end
      chk(wb_n - wb0 == (v.kind == 2'd2 ? 1 : 0), "R5/R6 write-back count",
          128'(wb_n - wb0), 128'(v.kind == 2'd2 ? 1 : 0));
      chk(rf_n - rf0 == (v.kind != 2'd0 ? 1 : 0), "R3/R6 refill count",
          128'(rf_n - rf0), 128'(v.kind != 2'd0 ? 1 : 0));
      if (v.kind == 2'd2) begin
        chk(wb_addr_last == v.wbaddr, "R5 victim address", 128'(wb_addr_last), 128'(v.wbaddr));
        for (int w = 0; w < 4; w++)
          chk(wb_data_last[32*w +: 32] == gold[(v.wbaddr[9:0] + 10'(w))],
              "R5 R2 victim word", 128'(wb_data_last[32*w +: 32]),
              128'(gold[(v.wbaddr[9:0] + 10'(w))]));
      end
      if (v.kind != 2'd0)
        chk(rf_addr_last == {v.addr[31:2], 2'b00}, "R6 refill address",
            128'(rf_addr_last), 128'({v.addr[31:2], 2'b00}));
      if (v.wr) gold[v.addr[9:0]] = v.data;
      else chk(rd == gold[v.addr[9:0]], "R3/R7 read data R2 word select",
               128'(rd), 128'(gold[v.addr[9:0]]));
    end

    // R8: request held during a busy miss is ignored
    mem_lat = 3;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_0040; req_wdata = '0;
    @(negedge clk);
    req_write = 1'b1; req_addr = 32'h0000_0041; req_wdata = 32'hBAD0_BAD0;
    for (int k = 0; k < 3; k++) begin
      chk(busy, "R8 busy during miss", 128'(busy), 128'd1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_done && lat < 60) begin @(negedge clk); lat++; end
    chk(rsp_rdata == gold[10'h040], "R8 first request result", 128'(rsp_rdata), 128'(gold[10'h040]));
    repeat (2) @(negedge clk);
    chk(!busy, "R8 second request not taken", 128'(busy), 128'd0);
    do_req(1'b0, 32'h0000_0041, '0, lat, rd);
    chk(rd == gold[10'h041], "R8 ignored write left word", 128'(rd), 128'(gold[10'h041]));
    chk(lat == 2, "R8 word still a plain hit", 128'(lat), 128'd2);

    // R1: reset drops a dirty line without write-back
    mem_lat = 1;
    do_req(1'b1, 32'h0000_0014, 32'h1111_2222, lat, rd);
    chk(lat == 2, "R4 write hit before reset", 128'(lat), 128'd2);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !rsp_done && !mem_rd && !mem_wr, "R1 outputs after reset",
        128'({busy, rsp_done, mem_rd, mem_wr}), 128'd0);
    rst_n = 1'b1;
    wb0 = wb_n; rf0 = rf_n;
    do_req(1'b0, 32'h0000_0114, '0, lat, rd);
    chk(wb_n == wb0, "R1 no write-back of dropped dirty line", 128'(wb_n - wb0), 128'd0);
    chk(rd == gold[10'h114], "R1 read after reset", 128'(rd), 128'(gold[10'h114]));
    wb0 = wb_n; rf0 = rf_n;
    do_req(1'b0, 32'h0000_0016, '0, lat, rd);
    chk(rf_n - rf0 == 1, "R1 line invalid after reset", 128'(rf_n - rf0), 128'd1);
    do_req(1'b0, 32'h0000_0014, '0, lat, rd);
    chk(rd == gold[10'h014], "R1 discarded write absent", 128'(rd), 128'(gold[10'h014]));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule